// File: doc/BRIEF.md
# Per-Core Power Gating Sequencer

This block steps one processor core of a small multi-core array through a safe power-down or power-up. It drives four control lines for every core: the isolation clamp, the power-switch request, the power-ready indication and the active-low power-on reset. After most steps it waits for the matching status feedback to come back from the power domain before it moves on. The analog switches, the regulator and the core itself sit outside the block and answer only through the feedback inputs. The feedback may arrive late or not at all.

A requester issues a one-cycle command. The command gives a direction and a target core, named as a cluster number and a core number within that cluster. An early-boot command instead powers down every secondary core that physically exists. The block raises `busy` while it runs and pulses `done` when it stops. On that pulse, `err` shows whether a confirmation failed. A build-time variant adds a pre-step before power-up: it programs an 8-bit power-switch finger field and waits one settle interval.

Top module: `core_pwr_gate_seq`

## Requirements
- R1: A power-down drives the target core's lines in this order. First it sets the isolation clamp and confirms `iso_st` high. Then it clears the switch request and confirms `sw_st` low. Then it clears power-ready with no confirmation. Finally it drives `por_n` low and confirms `por_st` low. The switch request never falls while isolation is off.
- R2: A power-up drives the lines in this order. It sets the switch request, waits out the settle time, sets power-ready and confirms `rdy_st` high. It then clears isolation and confirms `iso_st` low. Last, it drives `por_n` high and confirms `por_st` high. Power-ready never rises without the switch request. Reset is never released while isolation is on or while ready is low.
- R3: The rise of the switch request and the rise of power-ready are separated by at least CLK_MHZ × SETTLE_US cycles and by at most two cycles more.
- R4: Each confirmation samples its feedback on at most POLL_MAX cycles. For the switch, ready and reset confirmations, a missing level ends the command with `err` high.
- R5: When an isolation confirmation runs out of polls, the sequence carries on as though it had been confirmed, and the command ends without an error.
- R6: With ALT_VARIANT set, a power-up first writes FINGER_VAL (default 0xFC) into `finger` and waits one settle interval before it raises the switch request. `finger` resets to 0.
- R7: An early-boot command powers down core 1. It then powers down the cores of the second cluster (cores 2 and 3) only when `cluster1_fused` is low. A set `cluster1_fused` means the second cluster is absent.
- R8: The target core index is `cmd_cluster` × CORES_PER_CL + `cmd_local`.
- R9: A `cmd_go` that arrives while `busy` is high is ignored. `done` is a one-cycle pulse that coincides with the first cycle in which `busy` is low.
- R10: `err` stays set until the next accepted command clears it. When a command fails, every control output keeps the level it last had. No output changes while the block is idle.
- R11: After reset, every core is powered and running. Isolation is 0, the switch request, power-ready and `por_n` are all 1, `busy`, `done` and `err` are 0, and `finger` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | One-cycle command strobe |
| cmd_up | input | 1 | 1 = power up, 0 = power down |
| cmd_early | input | 1 | Early-boot mode: power down all existing secondary cores |
| cmd_cluster | input | CL_W | Cluster number of the target |
| cmd_local | input | LC_W | Core number within the cluster |
| cluster1_fused | input | 1 | High when the second cluster is absent |
| iso_st | input | N_CORES | Isolation status feedback per core |
| sw_st | input | N_CORES | Power-switch status feedback per core |
| rdy_st | input | N_CORES | Power-ready status feedback per core |
| por_st | input | N_CORES | Reset status feedback per core (1 = released) |
| iso_en | output | N_CORES | Isolation clamp per core |
| sw_req | output | N_CORES | Power-switch request per core (1 = on) |
| pwr_rdy | output | N_CORES | Power-ready per core |
| por_n | output | N_CORES | Active-low power-on reset per core |
| finger | output | 8 | Power-switch finger field |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Sticky failure flag |

## Verification
On every cycle the assertions check the ordering invariants between each core's control lines. The switch request may fall only under isolation, ready may rise only with the switch on, reset may be released only on a clamped-free, ready core, and the finger value must be in place at any switch rise. They also check that an idle block holds all its outputs, that a failure always raises `err` together with `done`, and that the settle wait is entered before ready. Several behaviours are shown only by the bench's scenarios: the actual settle length, the poll bound under feedback that never arrives, the non-fatal isolation timeout, early-boot core selection with and without the second cluster, index arithmetic, and the clearing of a sticky error.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_FING, ST_FWAIT,
    ST_SW_ON, ST_SWAIT,
    ST_RDY_ON, ST_RDY_CHK,
    ST_ISO_OFF, ST_ISO_OFF_CHK,
    ST_POR_REL, ST_POR_REL_CHK,
    ST_ISO_ON, ST_ISO_ON_CHK,
    ST_SW_OFF, ST_SW_OFF_CHK,
    ST_RDY_OFF,
    ST_POR_SET, ST_POR_SET_CHK
  } cpg_state_e;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_ISO_SET, OP_ISO_CLR,
    OP_SW_SET,  OP_SW_CLR,
    OP_RDY_SET, OP_RDY_CLR,
    OP_RST_HOLD, OP_RST_FREE
  } cpg_op_e;

  // flat core number from cluster / local position
  function automatic int abs_core(input int cl, input int lc, input int per_cl);
    return cl * per_cl + lc;
  endfunction

  // settle length in cycles from clock rate and wait time
  function automatic int settle_cycles(input int mhz, input int us);
    return mhz * us;
  endfunction

  // early-boot walk: does a core follow 'cur' that must be gated?
  function automatic bit early_has_next(input int cur, input int n, input int per_cl,
                                        input bit second_absent);
    int nxt;
    nxt = cur + 1;
    return (nxt < n) && (!second_absent || nxt < per_cl);
  endfunction

endpackage

// File: rtl/cpg_delay.sv
module cpg_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // the sequencer must stop polling once the budget is spent
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !zero);
endmodule

// File: rtl/cpg_rail_bank.sv
module cpg_rail_bank
  import cpg_pkg::*;
#(
  parameter int N_CORES = 4,
  localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cpg_op_e            op,
  input  logic [IDX_W-1:0]   tgt,
  output logic [N_CORES-1:0] iso_en,
  output logic [N_CORES-1:0] sw_req,
  output logic [N_CORES-1:0] pwr_rdy,
  output logic [N_CORES-1:0] por_n
);
  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    logic hit;
    assign hit = (op != OP_NONE) && (tgt == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        iso_en[i]  <= 1'b0;
        sw_req[i]  <= 1'b1;
        pwr_rdy[i] <= 1'b1;
        por_n[i]   <= 1'b1;
      end else if (hit) begin
        case (op)
          OP_ISO_SET:  iso_en[i]  <= 1'b1;
          OP_ISO_CLR:  iso_en[i]  <= 1'b0;
          OP_SW_SET:   sw_req[i]  <= 1'b1;
          OP_SW_CLR:   sw_req[i]  <= 1'b0;
          OP_RDY_SET:  pwr_rdy[i] <= 1'b1;
          OP_RDY_CLR:  pwr_rdy[i] <= 1'b0;
          OP_RST_HOLD: por_n[i]   <= 1'b0;
          OP_RST_FREE: por_n[i]   <= 1'b1;
          default: ;
        endcase
      end
    end

    assert_iso_before_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_req[i]) |-> iso_en[i]);
    assert_rdy_needs_sw_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_rdy[i]) |-> sw_req[i]);
    assert_por_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(por_n[i]) |-> (sw_req[i] && pwr_rdy[i] && !iso_en[i]));
  end
endmodule

// File: rtl/cpg_fsm.sv
module cpg_fsm
  import cpg_pkg::*;
#(
  parameter int N_CORES      = 4,
  parameter int CORES_PER_CL = 2,
  parameter bit ALT_VARIANT  = 1'b0,
  parameter int TW           = 8,
  parameter int SETTLE_LD    = 1,
  parameter int POLL_LD      = 1,
  localparam int IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int NCL   = N_CORES / CORES_PER_CL,
  localparam int CL_W  = (NCL > 1) ? $clog2(NCL) : 1,
  localparam int LC_W  = (CORES_PER_CL > 1) ? $clog2(CORES_PER_CL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_go,
  input  logic             cmd_up,
  input  logic             cmd_early,
  input  logic [CL_W-1:0]  cmd_cluster,
  input  logic [LC_W-1:0]  cmd_local,
  input  logic             cluster1_fused,
  input  logic             fb_iso,
  input  logic             fb_sw,
  input  logic             fb_rdy,
  input  logic             fb_por,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val,
  output logic             tmr_dec,
  output cpg_op_e          op,
  output logic [IDX_W-1:0] tgt,
  output logic             fing_wr,
  output logic             busy,
  output logic             done,
  output logic             err
);
  cpg_state_e state_q, state_d;
  logic [IDX_W-1:0] tgt_q;
  logic early_q, fused_q;
  logic done_q, err_q;

  // named internal events
  logic accept_evt, fin_evt, fail_evt, adv_evt;

  assign accept_evt = (state_q == ST_IDLE) && cmd_go;

  always_comb begin
    state_d  = state_q;
    op       = OP_NONE;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    fing_wr  = 1'b0;
    fin_evt  = 1'b0;
    fail_evt = 1'b0;
    adv_evt  = 1'b0;
    case (state_q)
      ST_IDLE: if (cmd_go) begin
        if (cmd_up) state_d = ALT_VARIANT ? ST_FING : ST_SW_ON;
        else        state_d = ST_ISO_ON;
      end
      // ---------------- power-up path ----------------
      ST_FING: begin
        fing_wr = 1'b1; tmr_load = 1'b1; tmr_val = TW'(SETTLE_LD);
        state_d = ST_FWAIT;
      end
      ST_FWAIT: if (tmr_zero) state_d = ST_SW_ON; else tmr_dec = 1'b1;
      ST_SW_ON: begin
        op = OP_SW_SET; tmr_load = 1'b1; tmr_val = TW'(SETTLE_LD);
        state_d = ST_SWAIT;
      end
      ST_SWAIT: if (tmr_zero) state_d = ST_RDY_ON; else tmr_dec = 1'b1;
      ST_RDY_ON: begin
        op = OP_RDY_SET; tmr_load = 1'b1; tmr_val = TW'(POLL_LD);
        state_d = ST_RDY_CHK;
      end
      ST_RDY_CHK: begin
        if (fb_rdy)        state_d = ST_ISO_OFF;
        else if (tmr_zero) fail_evt = 1'b1;
        else               tmr_dec = 1'b1;
      end
      ST_ISO_OFF: begin
        op = OP_ISO_CLR; tmr_load = 1'b1; tmr_val = TW'(POLL_LD);
        state_d = ST_ISO_OFF_CHK;
      end
      ST_ISO_OFF_CHK: begin
        if (!fb_iso || tmr_zero) state_d = ST_POR_REL;
        else                     tmr_dec = 1'b1;
      end
      ST_POR_REL: begin
        op = OP_RST_FREE; tmr_load = 1'b1; tmr_val = TW'(POLL_LD);
        state_d = ST_POR_REL_CHK;
      end
      ST_POR_REL_CHK: begin
        if (fb_por)        fin_evt = 1'b1;
        else if (tmr_zero) fail_evt = 1'b1;
        else               tmr_dec = 1'b1;
      end
      // ---------------- power-down path ----------------
      ST_ISO_ON: begin
        op = OP_ISO_SET; tmr_load = 1'b1; tmr_val = TW'(POLL_LD);
        state_d = ST_ISO_ON_CHK;
      end
      ST_ISO_ON_CHK: begin
        if (fb_iso || tmr_zero) state_d = ST_SW_OFF;
        else                    tmr_dec = 1'b1;
      end
      ST_SW_OFF: begin
        op = OP_SW_CLR; tmr_load = 1'b1; tmr_val = TW'(POLL_LD);
        state_d = ST_SW_OFF_CHK;
      end
      ST_SW_OFF_CHK: begin
        if (!fb_sw)        state_d = ST_RDY_OFF;
        else if (tmr_zero) fail_evt = 1'b1;
        else               tmr_dec = 1'b1;
      end
      ST_RDY_OFF: begin
        op = OP_RDY_CLR; state_d = ST_POR_SET;
      end
      ST_POR_SET: begin
        op = OP_RST_HOLD; tmr_load = 1'b1; tmr_val = TW'(POLL_LD);
        state_d = ST_POR_SET_CHK;
      end
      ST_POR_SET_CHK: begin
        if (!fb_por) begin
          if (early_q && early_has_next(int'(tgt_q), N_CORES, CORES_PER_CL, fused_q)) begin
            adv_evt = 1'b1;
            state_d = ST_ISO_ON;
          end else begin
            fin_evt = 1'b1;
          end
        end else if (tmr_zero) fail_evt = 1'b1;
        else                   tmr_dec = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (fin_evt || fail_evt) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      early_q <= 1'b0;
      fused_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_evt || fail_evt;
      if (accept_evt) begin
        err_q   <= 1'b0;
        early_q <= cmd_early && !cmd_up;
        fused_q <= cluster1_fused;
        tgt_q   <= (cmd_early && !cmd_up) ? IDX_W'(1)
                 : IDX_W'(abs_core(int'(cmd_cluster), int'(cmd_local), CORES_PER_CL));
      end else if (fail_evt) begin
        err_q <= 1'b1;
      end
      if (adv_evt) tgt_q <= tgt_q + 1'b1;
    end
  end

  assign tgt  = tgt_q;
  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;

  assert_fail_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> (err && done));
  assert_settle_before_rdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RDY_ON) |-> ($past(state_q) == ST_SWAIT));
endmodule

// File: rtl/core_pwr_gate_seq.sv
module core_pwr_gate_seq
  import cpg_pkg::*;
#(
  parameter int         N_CORES      = 4,
  parameter int         CORES_PER_CL = 2,
  parameter int         CLK_MHZ      = 125,
  parameter int         SETTLE_US    = 100,
  parameter int         POLL_MAX     = 2000,
  parameter bit         ALT_VARIANT  = 1'b0,
  parameter logic [7:0] FINGER_VAL   = 8'hFC,
  localparam int IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int NCL   = N_CORES / CORES_PER_CL,
  localparam int CL_W  = (NCL > 1) ? $clog2(NCL) : 1,
  localparam int LC_W  = (CORES_PER_CL > 1) ? $clog2(CORES_PER_CL) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_go,
  input  logic               cmd_up,
  input  logic               cmd_early,
  input  logic [CL_W-1:0]    cmd_cluster,
  input  logic [LC_W-1:0]    cmd_local,
  input  logic               cluster1_fused,
  input  logic [N_CORES-1:0] iso_st,
  input  logic [N_CORES-1:0] sw_st,
  input  logic [N_CORES-1:0] rdy_st,
  input  logic [N_CORES-1:0] por_st,
  output logic [N_CORES-1:0] iso_en,
  output logic [N_CORES-1:0] sw_req,
  output logic [N_CORES-1:0] pwr_rdy,
  output logic [N_CORES-1:0] por_n,
  output logic [7:0]         finger,
  output logic               busy,
  output logic               done,
  output logic               err
);
  localparam int SETTLE_CYC = settle_cycles(CLK_MHZ, SETTLE_US);
  localparam int CNT_MAX    = (SETTLE_CYC > POLL_MAX) ? SETTLE_CYC : POLL_MAX;
  localparam int TW         = $clog2(CNT_MAX + 1);

  logic          tmr_load, tmr_dec, tmr_zero, fing_wr;
  logic [TW-1:0] tmr_val;
  logic [IDX_W-1:0] tgt;
  cpg_op_e       op;

  cpg_fsm #(
    .N_CORES(N_CORES), .CORES_PER_CL(CORES_PER_CL), .ALT_VARIANT(ALT_VARIANT),
    .TW(TW), .SETTLE_LD(SETTLE_CYC - 1), .POLL_LD(POLL_MAX - 1)
  ) u_fsm (
    .clk, .rst_n, .cmd_go, .cmd_up, .cmd_early, .cmd_cluster, .cmd_local,
    .cluster1_fused,
    .fb_iso(iso_st[tgt]), .fb_sw(sw_st[tgt]), .fb_rdy(rdy_st[tgt]), .fb_por(por_st[tgt]),
    .tmr_zero, .tmr_load, .tmr_val, .tmr_dec, .op, .tgt, .fing_wr,
    .busy, .done, .err
  );

  cpg_delay #(.W(TW)) u_delay (
    .clk, .rst_n, .load(tmr_load), .load_val(tmr_val), .dec(tmr_dec), .zero(tmr_zero)
  );

  cpg_rail_bank #(.N_CORES(N_CORES)) u_bank (
    .clk, .rst_n, .op, .tgt, .iso_en, .sw_req, .pwr_rdy, .por_n
  );

  if (ALT_VARIANT) begin : g_finger
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       finger <= 8'h00;
      else if (fing_wr) finger <= FINGER_VAL;
    end
    assert_finger_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sw_req & ~$past(sw_req))) |-> (finger == FINGER_VAL));
  end else begin : g_nofinger
    logic unused_fing;
    assign unused_fing = fing_wr;
    assign finger = 8'h00;
  end

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(iso_en) && $stable(sw_req) && $stable(pwr_rdy) &&
               $stable(por_n) && $stable(finger)));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/sim_core_pwr_gate_seq.sv
module sim_core_pwr_gate_seq;
  localparam int SETTLE = 250;  // 125 MHz x 2 us
  localparam int POLLS  = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_go = 0, cmd_up = 0, cmd_early = 0, fused = 0;
  logic [0:0] cmd_cluster = '0, cmd_local = '0;
  logic [3:0] iso_st = 4'h0, sw_st = 4'hF, rdy_st = 4'hF, por_st = 4'hF;
  logic [3:0] p_iso = 4'h0, p_sw = 4'hF, p_rdy = 4'hF, p_por = 4'hF;
  logic [3:0] k_iso = 0, k_sw = 0, k_rdy = 0, k_por = 0;
  logic [3:0] iso_en, sw_req, pwr_rdy, por_n;
  logic [7:0] finger;
  logic busy, done, err;

  always #4 clk = ~clk;

  core_pwr_gate_seq #(.N_CORES(4), .CORES_PER_CL(2), .CLK_MHZ(125), .SETTLE_US(2),
                      .POLL_MAX(POLLS), .ALT_VARIANT(1'b1), .FINGER_VAL(8'hFC)) u0 (
    .clk, .rst_n, .cmd_go, .cmd_up, .cmd_early, .cmd_cluster, .cmd_local,
    .cluster1_fused(fused), .iso_st, .sw_st, .rdy_st, .por_st,
    .iso_en, .sw_req, .pwr_rdy, .por_n, .finger, .busy, .done, .err);

  // power-domain model: two-cycle echo, frozen where killed
  always @(posedge clk) begin
    p_iso <= iso_en; p_sw <= sw_req; p_rdy <= pwr_rdy; p_por <= por_n;
    for (int i = 0; i < 4; i++) begin
      if (!k_iso[i]) iso_st[i] <= p_iso[i];
      if (!k_sw[i])  sw_st[i]  <= p_sw[i];
      if (!k_rdy[i]) rdy_st[i] <= p_rdy[i];
      if (!k_por[i]) por_st[i] <= p_por[i];
    end
  end

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct {
    logic err; logic [3:0] iso, sw, rdy, por; logic [7:0] fing; string tag;
  } exp_t;
  exp_t q[$];

  function automatic exp_t mk(input logic e, input logic [3:0] i, s, r, p,
                              input logic [7:0] f, input string t);
    exp_t x;
    x.err = e; x.iso = i; x.sw = s; x.rdy = r; x.por = p; x.fing = f; x.tag = t;
    return x;
  endfunction

  // monitor: compare final levels at each completion pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) chk(1'b0, "R9 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(err == e.err,      {e.tag, " err"},     32'(err),     32'(e.err));
        chk(iso_en == e.iso,   {e.tag, " iso_en"},  32'(iso_en),  32'(e.iso));
        chk(sw_req == e.sw,    {e.tag, " sw_req"},  32'(sw_req),  32'(e.sw));
        chk(pwr_rdy == e.rdy,  {e.tag, " pwr_rdy"}, 32'(pwr_rdy), 32'(e.rdy));
        chk(por_n == e.por,    {e.tag, " por_n"},   32'(por_n),   32'(e.por));
        chk(finger == e.fing,  {e.tag, " finger"},  32'(finger),  32'(e.fing));
      end
    end
  end

  // R3: settle gap between switch rise and ready rise
  int t_sw[4];
  logic [3:0] sw_prev = 4'hF, rdy_prev = 4'hF;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 4; i++) begin
        if (sw_req[i] && !sw_prev[i]) t_sw[i] = cyc;
        if (pwr_rdy[i] && !rdy_prev[i])
          chk((cyc - t_sw[i]) >= SETTLE && (cyc - t_sw[i]) <= SETTLE + 2,
              "R3 settle gap", 32'(cyc - t_sw[i]), 32'(SETTLE));
      end
    end
    sw_prev = sw_req; rdy_prev = pwr_rdy;
  end

  int t_start;
  task automatic start_cmd(input logic up, input logic early, input logic cl,
                           input logic lc, input logic fz, input exp_t e);
    q.push_back(e);
    @(negedge clk);
    cmd_up = up; cmd_early = early; cmd_cluster = cl; cmd_local = lc; fused = fz;
    cmd_go = 1'b1; t_start = cyc;
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  bit fin = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(iso_en == 4'h0, "R11 iso_en", 32'(iso_en), 0);
    chk(sw_req == 4'hF, "R11 sw_req", 32'(sw_req), 32'hF);
    chk(pwr_rdy == 4'hF, "R11 pwr_rdy", 32'(pwr_rdy), 32'hF);
    chk(por_n == 4'hF, "R11 por_n", 32'(por_n), 32'hF);
    chk(finger == 8'h00, "R11 finger", 32'(finger), 0);
    chk({busy, done, err} == 3'b000, "R11 flags", 32'({busy, done, err}), 0);

    // R7 early boot, second cluster absent; R9 busy command ignored
    start_cmd(0, 1, 0, 0, 1, mk(0, 4'b0010, 4'b1101, 4'b1101, 4'b1101, 8'h00, "R7 single-cluster"));
    repeat (3) @(negedge clk);
    cmd_up = 1; cmd_early = 0; cmd_local = 0; cmd_go = 1;
    @(negedge clk); cmd_go = 0;
    wait_done();
    repeat (5) @(negedge clk);
    chk(!busy, "R9 ignored cmd", 32'(busy), 0);
    chk(q.size() == 0, "R9 one done", 32'(q.size()), 0);

    // R2 R6 power up core 1
    start_cmd(1, 0, 0, 1, 0, mk(0, 4'b0000, 4'b1111, 4'b1111, 4'b1111, 8'hFC, "R2 R6 up core1"));
    wait_done();

    // R7 R1 early boot with both clusters
    start_cmd(0, 1, 0, 0, 0, mk(0, 4'b1110, 4'b0001, 4'b0001, 4'b0001, 8'hFC, "R7 R1 dual-cluster"));
    wait_done();

    // R8 cluster 1 core 1 -> index 3
    start_cmd(1, 0, 1, 1, 0, mk(0, 4'b0110, 4'b1001, 4'b1001, 4'b1001, 8'hFC, "R8 up cl1 lc1"));
    wait_done();

    // R5 isolation feedback never answers: down completes without error
    k_iso = 4'b1000;
    start_cmd(0, 0, 1, 1, 0, mk(0, 4'b1110, 4'b0001, 4'b0001, 4'b0001, 8'hFC, "R5 iso timeout"));
    wait_done();
    chk((cyc - t_start) >= POLLS, "R5 poll spent", 32'(cyc - t_start), 32'(POLLS));
    k_iso = 4'b0000;

    // R4 R10 ready never answers on core 2 power-up
    k_rdy = 4'b0100;
    start_cmd(1, 0, 1, 0, 0, mk(1, 4'b1110, 4'b0101, 4'b0101, 4'b0001, 8'hFC, "R4 rdy timeout"));
    wait_done();
    repeat (30) @(negedge clk);
    chk(err, "R10 sticky err", 32'(err), 1);
    chk(sw_req == 4'b0101 && pwr_rdy == 4'b0101 && iso_en == 4'b1110 && por_n == 4'b0001,
        "R10 outputs held", 32'({iso_en, sw_req, pwr_rdy, por_n}), 32'h0E_55_1);
    k_rdy = 4'b0000;
    repeat (4) @(negedge clk);

    // R10 next command clears error; R1 down from partial state
    start_cmd(0, 0, 1, 0, 0, mk(0, 4'b1110, 4'b0001, 4'b0001, 4'b0001, 8'hFC, "R10 R1 clear err"));
    wait_done();

    // R4 switch never drops on core 0
    k_sw = 4'b0001;
    start_cmd(0, 0, 0, 0, 0, mk(1, 4'b1111, 4'b0000, 4'b0001, 4'b0001, 8'hFC, "R4 sw timeout"));
    wait_done();
    chk((cyc - t_start) >= POLLS && (cyc - t_start) <= POLLS + 12, "R4 poll bound",
        32'(cyc - t_start), 32'(POLLS));
    k_sw = 4'b0000;
    repeat (4) @(negedge clk);

    // R2 recover core 0
    start_cmd(1, 0, 0, 0, 0, mk(0, 4'b1110, 4'b0001, 4'b0001, 4'b0001, 8'hFC, "R2 up core0"));
    wait_done();
    chk(q.size() == 0, "R9 all done seen", 32'(q.size()), 0);

    if (!fin) begin
      fin = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule